// File: doc/BRIEF.md
# Dual-Pass Converter Histogram Collector

This block is a built-in self-test engine for measuring the static linearity of an analog-to-digital converter. It drives a digital-to-analog converter with a code ramp, and the converter's analog output feeds the converter under test. It makes two passes over the same ramp. In the first pass the offset-enable output is low. In the second pass it is high, so that an external switched generator adds a fixed analog shift to the stimulus. The converter's output codes, marked by a valid strobe, are binned into a separate code-density histogram for each pass.

A host reads the two histograms through a combinational read port, together with a count of the samples accepted. From these it solves for the stimulus density and derives the differential and integral nonlinearity, so the stimulus never has to be known in advance. The code width is a parameter. Twelve bits gives 4096 bins per histogram. The default is smaller to keep the register array modest.

Top module: `adc_hist_bist`

## Requirements
- R1: After reset the block is idle. `busy_o`, `done_o` and `ofs_en_o` are low, `dac_code_o` is 0, `smp_cnt_o` is 0, and every bin of both histograms reads 0.
- R2: A `clr_i` pulse while idle keeps `busy_o` high for 2^(CODE_W+1) cycles. After that, every bin of both histograms reads 0.
- R3: On a `start_i` pulse while idle, `dac_code_o` is 0 in the next cycle. It then rises by one per cycle, wrapping from 2^CODE_W-1 to 0, and each pass is `reps_i`+1 full sweeps, so one pass lasts 2^CODE_W·(`reps_i`+1) cycles.
- R4: `ofs_en_o` is low for the whole first pass and high for the whole second pass. It changes only where a sweep starts, and it is low whenever `busy_o` is low.
- R5: A sample is accepted on a rising edge where `adc_vld_i` is high during a pass. It adds one to bin `adc_code_i` of histogram 0 if `ofs_en_o` is low, and of histogram 1 if it is high. The new count is visible on the read port after the second rising edge that follows.
- R6: Accepted samples carrying the same code on consecutive cycles are each counted; none is lost.
- R7: A bin stops at 2^CNT_W-1 and never wraps.
- R8: A sample is ignored if `adc_vld_i` is low, or if it arrives while idle or clearing. Such a sample changes neither the bins nor `smp_cnt_o`.
- R9: `busy_o` falls and `done_o` pulses high for exactly one cycle on the edge after the last ramp step of the second pass.
- R10: `smp_cnt_o` is cleared on start and then equals the number of samples accepted in the run.
- R11: `rd_data_o` shows, combinationally, bin `rd_addr_i` of histogram `rd_sel_i` (0 = no offset, 1 = offset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Zero both histograms (taken when idle) |
| start_i | input | 1 | Begin a two-pass run (taken when idle) |
| reps_i | input | REP_W | Sweeps per pass minus one |
| dac_code_o | output | CODE_W | Ramp code to the stimulus converter |
| ofs_en_o | output | 1 | Offset generator switch enable |
| adc_code_i | input | CODE_W | Code from the converter under test |
| adc_vld_i | input | 1 | Sample strobe for `adc_code_i` |
| busy_o | output | 1 | Clearing or running |
| done_o | output | 1 | One-cycle run-complete pulse |
| rd_sel_i | input | 1 | Histogram select for readout |
| rd_addr_i | input | CODE_W | Bin select for readout |
| rd_data_o | output | CNT_W | Selected bin count |
| smp_cnt_o | output | SMP_W | Samples accepted in the current or last run |

## Verification
The ramp code and the offset enable are registered. Each takes its new value one cycle after the start edge and steps once per cycle after that. The bench samples them at every falling edge and compares them against a cycle count kept from the start. A bin updates on the second rising edge after the sample is taken. `done_o` rises on the same edge where `busy_o` falls. The bench therefore checks `done_o` at the first falling edge where `busy_o` is low, and lets three cycles pass before reading any bin. `rd_data_o` is combinational, so the bench reads it one time step after setting the address.

// File: rtl/adc_hist_bist.sv
module adc_hist_bist #(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 16,
  parameter int REP_W  = 8,
  parameter int SMP_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic [REP_W-1:0]  reps_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              ofs_en_o,
  input  logic [CODE_W-1:0] adc_code_i,
  input  logic              adc_vld_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic              rd_sel_i,
  input  logic [CODE_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic [SMP_W-1:0]  smp_cnt_o
);
  localparam int BINS  = 1 << CODE_W;
  localparam int DEPTH = 2 * BINS;
  localparam int AW    = CODE_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_CLR, S_P0, S_P1} state_t;

  state_t            state_q;
  logic [AW-1:0]     clr_idx_q;
  logic [REP_W-1:0]  reps_q, sweep_q;
  logic [CNT_W-1:0]  mem [DEPTH];
  logic              s1_vld_q, wr_vld_q;
  logic [AW-1:0]     s1_addr_q, wr_addr_q;
  logic [CNT_W-1:0]  rd_q, wr_data_q, base, wdata;
  logic              in_pass, accept;

  assign in_pass   = (state_q == S_P0) || (state_q == S_P1);
  assign accept    = in_pass && adc_vld_i;
  assign busy_o    = state_q != S_IDLE;
  assign ofs_en_o  = state_q == S_P1;
  assign rd_data_o = mem[{rd_sel_i, rd_addr_i}];
  assign base      = (wr_vld_q && wr_addr_q == s1_addr_q) ? wr_data_q : rd_q;
  assign wdata     = (&base) ? base : base + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      clr_idx_q  <= '0;
      reps_q     <= '0;
      sweep_q    <= '0;
      dac_code_o <= '0;
      done_o     <= 1'b0;
      smp_cnt_o  <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (clr_i) begin
            state_q   <= S_CLR;
            clr_idx_q <= '0;
          end else if (start_i) begin
            state_q    <= S_P0;
            reps_q     <= reps_i;
            sweep_q    <= '0;
            dac_code_o <= '0;
            smp_cnt_o  <= '0;
          end
        end
        S_CLR: begin
          clr_idx_q <= clr_idx_q + 1'b1;
          if (&clr_idx_q) state_q <= S_IDLE;
        end
        default: begin
          if (adc_vld_i) smp_cnt_o <= smp_cnt_o + 1'b1;
          dac_code_o <= dac_code_o + 1'b1;
          if (&dac_code_o) begin
            if (sweep_q == reps_q) begin
              sweep_q <= '0;
              if (state_q == S_P0) state_q <= S_P1;
              else begin
                state_q <= S_IDLE;
                done_o  <= 1'b1;
              end
            end else begin
              sweep_q <= sweep_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q  <= 1'b0;
      s1_addr_q <= '0;
      rd_q      <= '0;
      wr_vld_q  <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (state_q == S_CLR) begin
      s1_vld_q       <= 1'b0;
      wr_vld_q       <= 1'b0;
      mem[clr_idx_q] <= '0;
    end else begin
      s1_vld_q  <= accept;
      s1_addr_q <= {ofs_en_o, adc_code_i};
      rd_q      <= mem[{ofs_en_o, adc_code_i}];
      wr_vld_q  <= s1_vld_q;
      wr_addr_q <= s1_addr_q;
      wr_data_q <= wdata;
      if (s1_vld_q) mem[s1_addr_q] <= wdata;
    end
  end

  AST_IDLE_NO_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !ofs_en_o); // R4
  AST_OFS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pass && dac_code_o != '0) |-> $stable(ofs_en_o)); // R4
  AST_DAC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pass && $past(in_pass)) |-> dac_code_o == CODE_W'($past(dac_code_o) + 1'b1)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R9
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld_q |-> wr_data_q != '0); // R7
endmodule

// File: tb/adc_hist_bist_tb.sv
module adc_hist_bist_tb;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 6;
  localparam int REP_W  = 4;
  localparam int SMP_W  = 16;
  localparam int BINS   = 1 << CODE_W;
  localparam int OFS    = 3;

  // {sel[12], addr[11:8], expected count[7:0]} after an ideal run with reps=2
  localparam logic [15:0] VEC [8] = '{
    16'h0003, 16'h0703, 16'h0F03, 16'h1000,
    16'h1200, 16'h1303, 16'h1903, 16'h1F0C
  };

  logic clk = 1'b0, rst_n = 1'b0, clr_i = 1'b0, start_i = 1'b0, adc_vld_i = 1'b0, rd_sel_i = 1'b0;
  logic [REP_W-1:0]  reps_i = '0;
  logic [CODE_W-1:0] adc_code_i = '0, rd_addr_i = '0;
  logic [CODE_W-1:0] dac_code_o;
  logic ofs_en_o, busy_o, done_o;
  logic [CNT_W-1:0] rd_data_o;
  logic [SMP_W-1:0] smp_cnt_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  adc_hist_bist #(.CODE_W(CODE_W), .CNT_W(CNT_W), .REP_W(REP_W), .SMP_W(SMP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .start_i(start_i), .reps_i(reps_i),
    .dac_code_o(dac_code_o), .ofs_en_o(ofs_en_o), .adc_code_i(adc_code_i),
    .adc_vld_i(adc_vld_i), .busy_o(busy_o), .done_o(done_o), .rd_sel_i(rd_sel_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .smp_cnt_o(smp_cnt_o));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd_bin(input logic sel, input int addr, output int val);
    rd_sel_i  = sel;
    rd_addr_i = CODE_W'(addr);
    #1 val = int'(rd_data_o);
  endtask

  task automatic do_clear();
    int cyc = 0;
    @(negedge clk) clr_i = 1'b1;
    @(negedge clk) clr_i = 1'b0;
    while (busy_o) begin
      cyc++;
      @(negedge clk);
    end
    check("R2 clear busy cycles", cyc, 2 * BINS);
  endtask

  // mode 0: ideal loop with offset, 1: constant code, 2: strobe held low
  task automatic do_run(input int reps, input int mode, input int code);
    int cyc = 0, plen = BINS * (reps + 1), bad_dac = 0, bad_ofs = 0, v;
    @(negedge clk) begin reps_i = REP_W'(reps); start_i = 1'b1; end
    @(negedge clk) start_i = 1'b0;
    while (busy_o) begin
      if (int'(dac_code_o) != cyc % BINS) bad_dac++;
      if (ofs_en_o != (cyc >= plen)) bad_ofs++;
      if (done_o) bad_ofs++;
      adc_vld_i = (mode != 2);
      if (mode == 1) adc_code_i = CODE_W'(code);
      else begin
        v = int'(dac_code_o) + (ofs_en_o ? OFS : 0);
        adc_code_i = CODE_W'((v > BINS - 1) ? BINS - 1 : v);
      end
      cyc++;
      @(negedge clk);
    end
    adc_vld_i = 1'b0;
    check("R3 run length", cyc, 2 * plen);
    check("R3 ramp steps", bad_dac, 0);
    check("R4 offset enable per pass", bad_ofs, 0);
    check("R9 done at end", int'(done_o), 1);
    @(negedge clk) check("R9 done one cycle", int'(done_o), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 ofs", int'(ofs_en_o), 0);
    check("R1 dac", int'(dac_code_o), 0);
    check("R1 smp", int'(smp_cnt_o), 0);
    rd_bin(1'b1, 9, v); check("R1 bin zero", v, 0);
    rst_n = 1'b1;

    do_run(2, 0, 0);
    check("R10 sample count", int'(smp_cnt_o), 2 * BINS * 3);
    for (int i = 0; i < 8; i++) begin
      rd_bin(VEC[i][12], int'(VEC[i][11:8]), v);
      check($sformatf("R5 R11 hist%0d bin %0d", VEC[i][12], VEC[i][11:8]), v, int'(VEC[i][7:0]));
    end

    do_clear();
    for (int i = 0; i < BINS; i++) begin
      rd_bin(1'b0, i, v); check("R2 hist0 cleared", v, 0);
      rd_bin(1'b1, i, v); check("R2 hist1 cleared", v, 0);
    end

    // idle samples ignored
    @(negedge clk) begin adc_vld_i = 1'b1; adc_code_i = 4'd3; end
    repeat (5) @(negedge clk);
    adc_vld_i = 1'b0;
    repeat (3) @(negedge clk);
    rd_bin(1'b0, 3, v); check("R8 idle sample ignored", v, 0);
    check("R8 idle smp count", int'(smp_cnt_o), 2 * BINS * 3);

    // back-to-back identical codes
    do_run(0, 1, 7);
    rd_bin(1'b0, 7, v); check("R6 consecutive hist0", v, BINS);
    rd_bin(1'b1, 7, v); check("R6 consecutive hist1", v, BINS);
    rd_bin(1'b0, 6, v); check("R6 neighbour untouched", v, 0);

    do_clear();
    do_run(15, 1, 5);
    rd_bin(1'b0, 5, v); check("R7 saturate hist0", v, (1 << CNT_W) - 1);
    rd_bin(1'b1, 5, v); check("R7 saturate hist1", v, (1 << CNT_W) - 1);
    check("R10 long run count", int'(smp_cnt_o), 2 * BINS * 16);

    do_run(0, 2, 0);
    check("R8 no strobe count", int'(smp_cnt_o), 0);
    rd_bin(1'b0, 5, v); check("R8 bins kept hist0", v, (1 << CNT_W) - 1);
    rd_bin(1'b1, 0, v); check("R8 bins kept hist1", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule